// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block models the command side of a parallel NOR flash array that follows a multi-cycle, byte-coded command protocol. A host drives a synchronous bus with an address, write data, a write strobe and a read strobe. The block decodes command bytes written on the low data byte and holds a small byte-array store that comes out of reset fully erased. It carries out word programming, sector erase with a confirm byte, counted buffered writes with a confirm byte, status clearing, lock and unlock sequences, and switches among four read views: array data, status, identifier and query table.

The bus is `BANK_BYTES` wide and is made of `BANK_BYTES/DEV_BYTES` identical devices placed side by side. Status, identifier and query answers are therefore repeated in every device lane of a read. Reads return data one cycle after the read strobe. A separate read-only input stands in for a protected region: program and erase attempts then set error bits and leave the store untouched. Operations finish in the cycle of their final write. There is no busy time.

States: `ST_ARRAY`, `ST_STATUS`, `ST_ID` and `ST_QUERY` are the idle states, and in each of them a write is decoded as a new command. `ST_PROG` waits for program data. `ST_ERASE` waits for the erase confirm. `ST_BCOUNT` waits for the buffer count, `ST_BDATA` takes buffer data and `ST_BCONF` waits for the buffer confirm. `ST_LOCK` waits for the lock sub-command. Transitions: an idle state goes to the state its command selects. `ST_PROG` goes to `ST_STATUS`. `ST_ERASE`, `ST_BCONF` and `ST_LOCK` go to `ST_STATUS` on an accepted byte and to `ST_ARRAY` on any other byte. `ST_BCOUNT` goes to `ST_BDATA`. `ST_BDATA` stays in `ST_BDATA` until its count is spent, then goes to `ST_BCONF`.

Top module: `flc_top`

## Requirements
- R1: After reset every storage byte is 0xFF, the status byte is 0x00 and reads return array data.
- R2: Writing command 0x10 or 0x40 arms one program. The next write stores its full data word, little-endian, at the word containing its address and sets status bit 7 (0x80, ready). Reads then return status.
- R3: Command 0x20 followed by 0xD0 fills with 0xFF the whole `SECTOR_BYTES` sector containing the confirm address, leaves other sectors unchanged and sets status bit 7. Any byte other than 0xD0 in the confirm cycle, including 0xFF, returns to array reads without erasing.
- R4: Command 0xE8 sets status bit 7. The next write gives a count N taken from the low `8*DEV_BYTES` data bits. The next N+1 writes are stored as program data, and a following 0xD0 returns to status reads.
- R5: In the buffered-write confirm cycle, any byte other than 0xD0 returns to array reads. Data already written stays stored.
- R6: After command 0x60, a following 0x01 or 0xD0 sets status bit 7 and selects status reads. Any other byte, 0xFF included, selects array reads.
- R7: Command 0x50 clears the status byte to 0x00 and selects status reads. Command 0x70 selects status reads.
- R8: In status reads and while any multi-cycle command is pending, a read returns the status byte zero-extended in every `8*DEV_BYTES` lane. In array reads it returns the addressed word with the lowest byte address in bits 7:0.
- R9: After command 0x90, a read at device offset (address / `BANK_BYTES`) 0 returns `MANUF_ID`, at offset 1 returns `DEVICE_ID` and at other offsets returns 0, repeated in every lane.
- R10: After command 0x98, a read at device offset k returns query byte k in every lane. Offsets 0x10..0x12 hold 0x51, 0x52, 0x59. Offset 0x2A holds the write-buffer size exponent: 8 when `BANK_BYTES` is 1 and 11 otherwise. Offsets above 0x51 read 0.
- R11: In an idle state, a command byte outside {0x10, 0x20, 0x40, 0x50, 0x60, 0x70, 0x90, 0x98, 0xE8} (0xFF among them) selects array reads.
- R12: While `ro` is high, a program or buffered data write sets status bit 4 (0x10) and an erase confirm sets status bit 5 (0x20). Both also set bit 7, and storage stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wdata | input | 8*BANK_BYTES | Write data, command byte in bits 7:0 |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8*BANK_BYTES | Read data, valid the cycle after rd_en |
| ro | input | 1 | Treat the store as read-only |

## Verification
The bench uses the default build: a 2-byte bus made of two byte-wide devices, 256 bytes of store and 64-byte sectors. Two lanes make the status, identifier and query replication visible in each read. Four sectors let an erase be checked against an untouched neighbouring sector. The query exponent at offset 0x2A takes its multi-byte-bank value of 11. Random programs, erases and buffered writes with counts from 0 to 3 are mixed with directed abort, lock, read-only and unknown-command cases.

// File: rtl/flc_pkg.sv
package flc_pkg;
    typedef enum logic [3:0] {
        ST_ARRAY,
        ST_STATUS,
        ST_ID,
        ST_QUERY,
        ST_PROG,
        ST_ERASE,
        ST_BCOUNT,
        ST_BDATA,
        ST_BCONF,
        ST_LOCK
    } flc_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_ID,
        RM_QUERY
    } flc_rmode_e;

    localparam logic [7:0] OP_PROG_A  = 8'h10;
    localparam logic [7:0] OP_PROG_B  = 8'h40;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_CLEAR   = 8'h50;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_BUFWR   = 8'hE8;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_SETLOCK = 8'h01;

    localparam logic [7:0] SB_READY   = 8'h80;
    localparam logic [7:0] SB_ERASEER = 8'h20;
    localparam logic [7:0] SB_PROGER  = 8'h10;
endpackage

// File: rtl/flc_store.sv
module flc_store #(
    parameter int BANK_BYTES   = 2,
    parameter int ADDR_W       = 8,
    parameter int SECTOR_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [8*BANK_BYTES-1:0] wdata,
    input  logic                    we,
    input  logic                    erase_en,
    output logic [8*BANK_BYTES-1:0] rword
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    int word_idx;
    int sec_base;

    always_comb begin
        word_idx = int'(addr) / BANK_BYTES;
        sec_base = (int'(addr) / SECTOR_BYTES) * SECTOR_BYTES;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (erase_en && (i / SECTOR_BYTES) * SECTOR_BYTES == sec_base)
                    mem[i] <= 8'hFF;
                else if (we && (i / BANK_BYTES) == word_idx)
                    mem[i] <= wdata[8*(i % BANK_BYTES) +: 8];
            end
        end
    end

    genvar b;
    generate
        for (b = 0; b < BANK_BYTES; b++) begin : g_rd
            assign rword[8*b +: 8] = mem[ADDR_W'(word_idx * BANK_BYTES + b)];
        end
    endgenerate

    // R3: the first byte of an erased sector reads 0xFF right after the erase
    assert_erase_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> mem[ADDR_W'($past(sec_base))] == 8'hFF);
endmodule

// File: rtl/flc_readmux.sv
module flc_readmux
    import flc_pkg::*;
#(
    parameter int         BANK_BYTES   = 2,
    parameter int         DEV_BYTES    = 1,
    parameter int         ADDR_W       = 8,
    parameter int         SECTOR_BYTES = 64,
    parameter logic [7:0] MANUF_ID     = 8'h89,
    parameter logic [7:0] DEVICE_ID    = 8'h18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  flc_rmode_e              rmode,
    input  logic [7:0]              status,
    input  logic [8*BANK_BYTES-1:0] aword,
    output logic [8*BANK_BYTES-1:0] rdata
);
    localparam int DW       = 8 * BANK_BYTES;
    localparam int LW       = 8 * DEV_BYTES;
    localparam int NLANES   = BANK_BYTES / DEV_BYTES;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int DEV_SIZE = DEPTH / NLANES;
    localparam int BLK_DEV  = (DEPTH / SECTOR_BYTES) / NLANES;
    localparam int BUF_EXP  = (BANK_BYTES == 1) ? 8 : 11;
    localparam int TBL_LAST = 'h51;

    function automatic logic [7:0] query_byte(input int off);
        logic [7:0] v;
        v = 8'h00;
        if (off <= TBL_LAST) begin
            case (off)
                'h10: v = 8'h51;
                'h11: v = 8'h52;
                'h12: v = 8'h59;
                'h13: v = 8'h01;
                'h27: v = 8'($clog2(DEV_SIZE));
                'h28: v = 8'h02;
                'h2A: v = 8'(BUF_EXP);
                'h2C: v = 8'h01;
                'h2D: v = 8'(BLK_DEV - 1);
                'h2E: v = 8'((BLK_DEV - 1) >> 8);
                'h2F: v = 8'(SECTOR_BYTES >> 8);
                'h30: v = 8'(SECTOR_BYTES >> 16);
                default: v = 8'h00;
            endcase
        end
        return v;
    endfunction

    int            dev_off;
    logic [LW-1:0] lane_val;
    logic [DW-1:0] repl;
    logic [DW-1:0] rd_next;

    always_comb begin
        dev_off  = int'(addr) / BANK_BYTES;
        lane_val = '0;
        unique case (rmode)
            RM_STATUS: lane_val = LW'(status);
            RM_ID: begin
                if ((dev_off & 'hFF) == 0)      lane_val = LW'(MANUF_ID);
                else if ((dev_off & 'hFF) == 1) lane_val = LW'(DEVICE_ID);
                else                            lane_val = '0;
            end
            RM_QUERY: lane_val = LW'(query_byte(dev_off));
            default:  lane_val = '0;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < NLANES; g++) begin : g_lane
            assign repl[g*LW +: LW] = lane_val;
        end
    endgenerate

    assign rd_next = (rmode == RM_ARRAY) ? aword : repl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

    // R8: a status read carries the status byte in lane 0 and the same value in the top lane
    assert_status_lane0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rmode == RM_STATUS |=> rdata[7:0] == $past(status));
    assert_status_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rmode == RM_STATUS |=> rdata[DW-1 -: LW] == rdata[LW-1:0]);
endmodule

// File: rtl/flc_fsm.sv
module flc_fsm
    import flc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    cmd,
    input  logic [CW-1:0] count_val,
    input  logic          ro,
    output logic          prog_go,
    output logic          erase_go,
    output logic [7:0]    status,
    output flc_rmode_e    rmode
);
    flc_state_e    state_q, state_d;
    logic [7:0]    status_q, status_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          idle;

    assign idle = (state_q == ST_ARRAY) || (state_q == ST_STATUS) ||
                  (state_q == ST_ID)    || (state_q == ST_QUERY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_ARRAY;
            status_q <= 8'h00;
            cnt_q    <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
            cnt_q    <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        cnt_d    = cnt_q;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                ST_ARRAY, ST_STATUS, ST_ID, ST_QUERY: begin
                    case (cmd)
                        OP_PROG_A, OP_PROG_B: state_d = ST_PROG;
                        OP_ERASE:  state_d = ST_ERASE;
                        OP_BUFWR: begin
                            status_d = status_q | SB_READY;
                            state_d  = ST_BCOUNT;
                        end
                        OP_CLEAR: begin
                            status_d = 8'h00;
                            state_d  = ST_STATUS;
                        end
                        OP_LOCK:   state_d = ST_LOCK;
                        OP_STATUS: state_d = ST_STATUS;
                        OP_IDENT:  state_d = ST_ID;
                        OP_QUERY:  state_d = ST_QUERY;
                        default:   state_d = ST_ARRAY;
                    endcase
                end
                ST_PROG: begin
                    if (ro) status_d = status_q | SB_PROGER | SB_READY;
                    else begin
                        prog_go  = 1'b1;
                        status_d = status_q | SB_READY;
                    end
                    state_d = ST_STATUS;
                end
                ST_ERASE: begin
                    if (cmd == OP_CONFIRM) begin
                        if (ro) status_d = status_q | SB_ERASEER | SB_READY;
                        else begin
                            erase_go = 1'b1;
                            status_d = status_q | SB_READY;
                        end
                        state_d = ST_STATUS;
                    end else begin
                        state_d = ST_ARRAY;
                    end
                end
                ST_BCOUNT: begin
                    cnt_d   = count_val;
                    state_d = ST_BDATA;
                end
                ST_BDATA: begin
                    if (ro) status_d = status_q | SB_PROGER;
                    else    prog_go  = 1'b1;
                    if (cnt_q == '0) state_d = ST_BCONF;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                ST_BCONF: begin
                    if (cmd == OP_CONFIRM) begin
                        status_d = status_q | SB_READY;
                        state_d  = ST_STATUS;
                    end else begin
                        state_d = ST_ARRAY;
                    end
                end
                ST_LOCK: begin
                    if (cmd == OP_SETLOCK || cmd == OP_CONFIRM) begin
                        status_d = status_q | SB_READY;
                        state_d  = ST_STATUS;
                    end else begin
                        state_d = ST_ARRAY;
                    end
                end
                default: state_d = ST_ARRAY;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ARRAY: rmode = RM_ARRAY;
            ST_ID:    rmode = RM_ID;
            ST_QUERY: rmode = RM_QUERY;
            default:  rmode = RM_STATUS;
        endcase
    end

    assign status = status_q;

    function automatic logic is_known(input logic [7:0] c);
        return c == OP_PROG_A || c == OP_PROG_B || c == OP_ERASE || c == OP_CLEAR ||
               c == OP_LOCK || c == OP_STATUS || c == OP_IDENT || c == OP_QUERY ||
               c == OP_BUFWR;
    endfunction

    assert_prog_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && state_q == ST_PROG |=> status_q[7] && state_q == ST_STATUS);
    assert_buf_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && state_q == ST_BDATA && cnt_q == '0 |=> state_q == ST_BCONF);
    assert_buf_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && state_q == ST_BCONF && cmd != OP_CONFIRM |=> state_q == ST_ARRAY);
    assert_lock_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && state_q == ST_LOCK && cmd != OP_SETLOCK && cmd != OP_CONFIRM
        |=> state_q == ST_ARRAY);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && idle && cmd == OP_CLEAR |=> status_q == 8'h00);
    assert_unknown_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && idle && !is_known(cmd) |=> state_q == ST_ARRAY);
    assert_ro_guard_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ro |-> !prog_go && !erase_go);
    assert_ro_progerr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && ro && state_q == ST_PROG |=> status_q[4]);
endmodule

// File: rtl/flc_top.sv
module flc_top
    import flc_pkg::*;
#(
    parameter int         BANK_BYTES   = 2,
    parameter int         DEV_BYTES    = 1,
    parameter int         ADDR_W       = 8,
    parameter int         SECTOR_BYTES = 64,
    parameter logic [7:0] MANUF_ID     = 8'h89,
    parameter logic [7:0] DEVICE_ID    = 8'h18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic [8*BANK_BYTES-1:0] wdata,
    input  logic                    rd_en,
    output logic [8*BANK_BYTES-1:0] rdata,
    input  logic                    ro
);
    localparam int DW = 8 * BANK_BYTES;
    localparam int CW = 8 * DEV_BYTES;

    logic          prog_go, erase_go;
    logic [7:0]    status;
    flc_rmode_e    rmode;
    logic [DW-1:0] aword;

    flc_fsm #(.CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .cmd       (wdata[7:0]),
        .count_val (wdata[CW-1:0]),
        .ro        (ro),
        .prog_go   (prog_go),
        .erase_go  (erase_go),
        .status    (status),
        .rmode     (rmode)
    );

    flc_store #(
        .BANK_BYTES   (BANK_BYTES),
        .ADDR_W       (ADDR_W),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .we       (prog_go),
        .erase_en (erase_go),
        .rword    (aword)
    );

    flc_readmux #(
        .BANK_BYTES   (BANK_BYTES),
        .DEV_BYTES    (DEV_BYTES),
        .ADDR_W       (ADDR_W),
        .SECTOR_BYTES (SECTOR_BYTES),
        .MANUF_ID     (MANUF_ID),
        .DEVICE_ID    (DEVICE_ID)
    ) u_rmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .addr   (addr),
        .rmode  (rmode),
        .status (status),
        .aword  (aword),
        .rdata  (rdata)
    );
endmodule

// File: tb/tb_flc_top.sv
`timescale 1ns/1ps
module tb_flc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        ro = 1'b0;

    int checks = 0;
    int fails = 0;
    logic [7:0] mem_m [256];
    logic [7:0] st_m = 8'h00;

    always #2.5 clk = ~clk;

    flc_top dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .ro(ro)
    );

    function automatic logic [15:0] rep(input logic [7:0] b);
        return {b, b};
    endfunction

    function automatic logic [15:0] mword(input logic [7:0] a);
        logic [7:0] base;
        base = a & 8'hFE;
        return {mem_m[base + 8'd1], mem_m[base]};
    endfunction

    task automatic m_prog(input logic [7:0] a, input logic [15:0] d);
        logic [7:0] base;
        base = a & 8'hFE;
        mem_m[base] = d[7:0];
        mem_m[base + 8'd1] = d[15:8];
    endtask

    task automatic m_erase(input logic [7:0] a);
        for (int i = 0; i < 64; i++) mem_m[(a & 8'hC0) + 8'(i)] = 8'hFF;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        logic [7:0]  a;
        logic [15:0] d;
        int          n;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset: erased array, status 0
        rd_chk("R1 reset array", 8'h00, 16'hFFFF);
        rd_chk("R1 reset array hi", 8'hFE, 16'hFFFF);
        wr(8'h00, 16'h0070);
        rd_chk("R1/R7 reset status", 8'h00, rep(8'h00));

        // R2 program with both opcodes
        wr(8'h04, 16'h0040); wr(8'h04, 16'hA55A); m_prog(8'h04, 16'hA55A); st_m |= 8'h80;
        rd_chk("R2 status after program", 8'h04, rep(st_m));
        wr(8'h00, 16'h00FF);
        rd_chk("R2/R8 array word", 8'h04, 16'hA55A);
        wr(8'h07, 16'h0010); wr(8'h07, 16'h1234); m_prog(8'h07, 16'h1234);
        wr(8'h00, 16'h00FF);
        rd_chk("R2 opcode 0x10", 8'h06, 16'h1234);

        // R3 sector erase, neighbour untouched
        wr(8'h44, 16'h0040); wr(8'h44, 16'hBEEF); m_prog(8'h44, 16'hBEEF);
        wr(8'h80, 16'h0040); wr(8'h80, 16'h7777); m_prog(8'h80, 16'h7777);
        wr(8'h45, 16'h0020); wr(8'h45, 16'h00D0); m_erase(8'h45);
        rd_chk("R3 status after erase", 8'h00, rep(st_m));
        wr(8'h00, 16'h00FF);
        rd_chk("R3 erased word", 8'h44, 16'hFFFF);
        rd_chk("R3 neighbour sector", 8'h80, 16'h7777);
        wr(8'h80, 16'h0020); wr(8'h80, 16'h00FF);
        rd_chk("R3 erase aborted by 0xFF", 8'h80, 16'h7777);
        wr(8'h80, 16'h0020); wr(8'h80, 16'h0055);
        rd_chk("R3 erase aborted by other byte", 8'h80, 16'h7777);

        // R4 buffered write count 2 -> three data writes
        wr(8'h10, 16'h00E8); wr(8'h10, 16'h0002);
        wr(8'h10, 16'h1111); m_prog(8'h10, 16'h1111);
        rd_chk("R8 status lanes during buffer", 8'h10, rep(st_m));
        wr(8'h12, 16'h2222); m_prog(8'h12, 16'h2222);
        wr(8'h14, 16'h3333); m_prog(8'h14, 16'h3333);
        rd_chk("R4 still status before confirm", 8'h14, rep(st_m));
        wr(8'h14, 16'h00D0);
        rd_chk("R4 status after confirm", 8'h14, rep(st_m));
        wr(8'h00, 16'h00FF);
        rd_chk("R4 buffer word 0", 8'h10, 16'h1111);
        rd_chk("R4 buffer word 2", 8'h14, 16'h3333);

        // R5 buffered abort
        wr(8'h20, 16'h00E8); wr(8'h20, 16'h0000);
        wr(8'h20, 16'h4242); m_prog(8'h20, 16'h4242);
        wr(8'h20, 16'h0033);
        rd_chk("R5 abort returns array", 8'h20, 16'h4242);

        // R7 clear, R6 lock
        wr(8'h00, 16'h0050); st_m = 8'h00;
        rd_chk("R7 clear status", 8'h00, rep(8'h00));
        wr(8'h00, 16'h0060); wr(8'h00, 16'h0001); st_m |= 8'h80;
        rd_chk("R6 lock sets ready", 8'h00, rep(st_m));
        wr(8'h00, 16'h0060); wr(8'h00, 16'h00D0);
        rd_chk("R6 unlock status", 8'h00, rep(st_m));
        wr(8'h00, 16'h0060); wr(8'h00, 16'h0033);
        rd_chk("R6 unknown lock byte", 8'h20, 16'h4242);

        // R9 identifier
        wr(8'h00, 16'h0090);
        rd_chk("R9 manufacturer", 8'h00, 16'h8989);
        rd_chk("R9 device", 8'h02, 16'h1818);
        rd_chk("R9 other offset", 8'h04, 16'h0000);

        // R10 query
        wr(8'h00, 16'h0098);
        rd_chk("R10 Q", 8'h20, 16'h5151);
        rd_chk("R10 R", 8'h22, 16'h5252);
        rd_chk("R10 Y", 8'h24, 16'h5959);
        rd_chk("R10 buffer exponent", 8'h54, 16'h0B0B);
        rd_chk("R10 beyond table", 8'hB0, 16'h0000);
        wr(8'h00, 16'h00FF);
        rd_chk("R11 0xFF to array", 8'h20, 16'h4242);

        // R11 unknown command
        wr(8'h00, 16'h0070);
        wr(8'h00, 16'h0037);
        rd_chk("R11 unknown command", 8'h20, 16'h4242);

        // R12 read-only
        wr(8'h00, 16'h0050); st_m = 8'h00;
        ro = 1'b1;
        wr(8'h20, 16'h0040); wr(8'h20, 16'h1111); st_m |= 8'h90;
        rd_chk("R12 program error bits", 8'h20, rep(st_m));
        wr(8'h00, 16'h00FF);
        rd_chk("R12 program blocked", 8'h20, 16'h4242);
        wr(8'h00, 16'h0050); st_m = 8'h00;
        wr(8'h20, 16'h0020); wr(8'h20, 16'h00D0); st_m |= 8'hA0;
        rd_chk("R12 erase error bits", 8'h20, rep(st_m));
        wr(8'h00, 16'h00FF);
        rd_chk("R12 erase blocked", 8'h20, 16'h4242);
        ro = 1'b0;
        wr(8'h00, 16'h0050); st_m = 8'h00;

        // random mix
        for (int k = 0; k < 40; k++) begin
            a = 8'($urandom_range(0, 255));
            n = $urandom_range(0, 2);
            if (n == 0) begin
                d = 16'($urandom);
                wr(a, 16'h0040); wr(a, d); m_prog(a, d); st_m |= 8'h80;
                rd_chk("R2 random program status", a, rep(st_m));
            end else if (n == 1) begin
                wr(a, 16'h0020); wr(a, 16'h00D0); m_erase(a); st_m |= 8'h80;
                rd_chk("R3 random erase status", a, rep(st_m));
            end else begin
                int cnt;
                cnt = $urandom_range(0, 3);
                wr(a, 16'h00E8); st_m |= 8'h80;
                wr(a, 16'(cnt));
                for (int j = 0; j <= cnt; j++) begin
                    d = 16'($urandom);
                    wr(8'((a & 8'hFE) + 8'(2 * j)), d);
                    m_prog(8'((a & 8'hFE) + 8'(2 * j)), d);
                end
                wr(a, 16'h00D0);
                rd_chk("R4 random buffer status", a, rep(st_m));
            end
            wr(8'h00, 16'h00FF);
            for (int j = 0; j < 4; j++) begin
                logic [7:0] ra;
                ra = (j == 0) ? a : 8'($urandom_range(0, 255));
                rd_chk("R8 random array read", ra, mword(ra));
            end
        end
        report();
    end
endmodule